// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between an on-chip valid/ready request channel and an external asynchronous static RAM with a 15-bit word address, an 8-bit bidirectional data bus and three active-low strobes (chip select, write enable, output enable). Each accepted request is one word, either a read or a write. A write carries its own address and data. The block produces the strobe sequence for that word and counts clock cycles so that each strobe lasts at least as long as the RAM's nanosecond timing figures require. Those figures are parameters, and each is converted to cycles by rounding the division by the clock period up, with a floor of one cycle.

The data bus is split into an output value, a driver-enable for the pad's tristate buffer, and an input value. Read data is registered from the bus on the last cycle of the access, while the RAM is still selected and output-enabled. It is returned with a one-cycle done pulse.

States and transitions: IDLE goes to READ_ACCESS on an accepted read. READ_ACCESS goes to READ_CAPTURE when its count ends, and READ_CAPTURE goes back to IDLE. IDLE goes to WRITE_SETUP on an accepted write. If the previous access was a read, IDLE instead goes to TURNAROUND, which goes to WRITE_SETUP when its count ends. WRITE_SETUP goes to WRITE_PULSE, WRITE_PULSE goes to WRITE_END, and WRITE_END goes back to IDLE, each when its count ends.

Top module: `asram_ctl`

## Requirements
- R1: During and right after reset, req_ready is 1, sram_cs_n, sram_we_n and sram_oe_n are all 1, dq_oe is 0 and rd_done is 0.
- R2: Strobe encodings are as follows. A read holds cs_n=0, oe_n=0 and we_n=1. A write window holds cs_n=0 and we_n=0, with oe_n=1 for its whole length. Outside any access all three strobes are 1.
- R3: A read holds cs_n and oe_n low for exactly ACC_C cycles. ACC_C is the largest of the cycle counts for the address access time, the output-enable access time and the read cycle time. The bus is sampled on the last of those cycles.
- R4: rd_done is high for exactly one cycle, in the cycle right after the read strobes rise. In that cycle rd_data holds the word sampled at the end of the access.
- R5: cs_n and we_n fall together and rise together, and stay low for exactly WP_C cycles. WP_C is the largest of the cycle counts for the write pulse, the data overlap and chip-select-to-end, and the address-to-end count less the setup cycles.
- R6: dq_oe is high for the setup cycle before the write window, for every cycle of the window and for at least one cycle after it. dq_out carries the request's write data throughout.
- R7: sram_addr equals the accepted request's address and does not change while cs_n is low.
- R8: After a read, dq_oe stays 0 for at least FLT_C cycles after oe_n rises, where FLT_C is the cycle count of the output float time. A write that follows a read spends FLT_C extra cycles before its setup.
- R9: req_ready is 1 only when the block is idle. A request is taken only in a cycle with req_valid and req_ready both 1. A request held valid while the block is busy is taken exactly once.
- R10: req_ready is low for ACC_C+1 cycles per read. For a write it is low for SU_C+WP_C+END_C cycles, plus FLT_C after a read. END_C is large enough to bring the write to at least the write cycle time.
- R11: dq_oe is never 1 while oe_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_data | output | DATA_W | Word read from the RAM |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| dq_out | output | DATA_W | Value for the data pad driver |
| dq_oe | output | 1 | Data pad driver enable |
| dq_in | input | DATA_W | Value seen on the data pads |

## Verification
The assertions assume that a pending request keeps its fields unchanged until it is taken. They also assume that dq_in is meaningful only while the RAM is selected and output-enabled. The bench drives each request at a falling edge and holds it until the first rising edge at which req_ready was seen high. Its RAM model returns a junk value (8'hEE) until the read strobes have been low for the full access count, so a capture that comes too early shows up as wrong data.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RACC,
        S_RCAP,
        S_TURN,
        S_WSET,
        S_WPUL,
        S_WEND
    } asram_state_t;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int CW     = 4,
    parameter int ACC_C  = 9,
    parameter int FLT_C  = 3,
    parameter int SU_C   = 1,
    parameter int WP_C   = 8,
    parameter int END_C  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          t_zero,
    output logic          t_load,
    output logic [CW-1:0] t_val,
    output logic          accept,
    output logic          capture,
    output logic          req_ready,
    output logic          rd_done,
    output logic          cs_n,
    output logic          we_n,
    output logic          oe_n,
    output logic          drv_en
);

    asram_state_t st, nxt;
    logic         last_rd;

    // State register and read-history flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            last_rd <= 1'b0;
        end else begin
            st <= nxt;
            if (st == S_RCAP)
                last_rd <= 1'b1;
            else if (st == S_WSET)
                last_rd <= 1'b0;
        end
    end

    // Next state and phase counter loads
    always_comb begin
        nxt    = st;
        t_load = 1'b0;
        t_val  = '0;
        unique case (st)
            S_IDLE: begin
                if (req_valid) begin
                    t_load = 1'b1;
                    if (!req_write) begin
                        nxt   = S_RACC;
                        t_val = CW'(ACC_C - 1);
                    end else if (last_rd) begin
                        nxt   = S_TURN;
                        t_val = CW'(FLT_C - 1);
                    end else begin
                        nxt   = S_WSET;
                        t_val = CW'(SU_C - 1);
                    end
                end
            end
            S_RACC: if (t_zero) begin
                nxt    = S_RCAP;
                t_load = 1'b1;
            end
            S_RCAP: nxt = S_IDLE;
            S_TURN: if (t_zero) begin
                nxt    = S_WSET;
                t_load = 1'b1;
                t_val  = CW'(SU_C - 1);
            end
            S_WSET: if (t_zero) begin
                nxt    = S_WPUL;
                t_load = 1'b1;
                t_val  = CW'(WP_C - 1);
            end
            S_WPUL: if (t_zero) begin
                nxt    = S_WEND;
                t_load = 1'b1;
                t_val  = CW'(END_C - 1);
            end
            S_WEND: if (t_zero) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        req_ready = (st == S_IDLE);
        accept    = (st == S_IDLE) && req_valid;
        capture   = (st == S_RACC) && t_zero;
        rd_done   = (st == S_RCAP);
        cs_n      = !((st == S_RACC) || (st == S_WPUL));
        oe_n      = !(st == S_RACC);
        we_n      = !(st == S_WPUL);
        drv_en    = (st == S_WSET) || (st == S_WPUL) || (st == S_WEND);
    end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture)
                rdata_q <= dq_in;
        end
    end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_AA_NS  = 85,
    parameter int T_OE_NS  = 45,
    parameter int T_RC_NS  = 85,
    parameter int T_WP_NS  = 55,
    parameter int T_CW_NS  = 75,
    parameter int T_AW_NS  = 75,
    parameter int T_DW_NS  = 40,
    parameter int T_AS_NS  = 0,
    parameter int T_WR_NS  = 0,
    parameter int T_WC_NS  = 85,
    parameter int T_FLT_NS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);

    localparam int ACC_C   = imax(imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)),
                                  ns2cyc(T_RC_NS, CLK_NS));
    localparam int FLT_C   = ns2cyc(T_FLT_NS, CLK_NS);
    localparam int SU_C    = ns2cyc(T_AS_NS, CLK_NS);
    localparam int WPMIN_C = ns2cyc(T_WP_NS, CLK_NS);
    localparam int WP_C    = imax(imax(WPMIN_C, ns2cyc(T_DW_NS, CLK_NS)),
                                  imax(ns2cyc(T_CW_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS) - SU_C));
    localparam int END_C   = imax(ns2cyc(T_WR_NS, CLK_NS), ns2cyc(T_WC_NS, CLK_NS) - SU_C - WP_C);
    localparam int MAX_C   = imax(imax(ACC_C, FLT_C), imax(imax(SU_C, WP_C), END_C));
    localparam int CW      = $clog2(MAX_C + 1);

    logic          t_load, t_zero, accept, capture;
    logic [CW-1:0] t_val;

    asram_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    asram_fsm #(
        .CW(CW), .ACC_C(ACC_C), .FLT_C(FLT_C),
        .SU_C(SU_C), .WP_C(WP_C), .END_C(END_C)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .t_zero    (t_zero),
        .t_load    (t_load),
        .t_val     (t_val),
        .accept    (accept),
        .capture   (capture),
        .req_ready (req_ready),
        .rd_done   (rd_done),
        .cs_n      (sram_cs_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .drv_en    (dq_oe)
    );

    asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (dq_in),
        .addr_q    (sram_addr),
        .wdata_q   (dq_out),
        .rdata_q   (rd_data)
    );

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
    parameter int ADDR_W  = 15,
    parameter int FLT_C   = 3,
    parameter int WPMIN_C = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_done,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              dq_oe
);

    logic [7:0]  gap;
    logic [15:0] wlen;

    // Cycles since output enable was last low (saturating)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap <= 8'hFF;
        else if (!sram_oe_n)
            gap <= 8'h00;
        else if (gap != 8'hFF)
            gap <= gap + 8'h01;
    end

    // Length of the current write-enable low run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wlen <= '0;
        else if (!sram_we_n)
            wlen <= wlen + 16'h1;
        else
            wlen <= '0;
    end

    p_write_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_cs_n));

    p_no_contention_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !dq_oe);

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && !dq_oe && !rd_done));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    p_float_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (int'(gap) >= FLT_C));

    p_pulse_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (int'(wlen) >= WPMIN_C));

    p_data_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> dq_oe);

endmodule

bind asram_ctl asram_chk #(
    .ADDR_W  (ADDR_W),
    .FLT_C   (FLT_C),
    .WPMIN_C (WPMIN_C)
) u_asram_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_done   (rd_done),
    .sram_addr (sram_addr),
    .sram_cs_n (sram_cs_n),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n),
    .dq_oe     (dq_oe)
);

// File: tb/test_asram_ctl.sv
module test_asram_ctl;

    localparam int CLK = 8;
    // Expected cycle counts, worked out from the timing figures at 8 ns
    localparam int ACC_E = 11;  // ceil(85/8)
    localparam int FLT_E = 4;   // ceil(30/8)
    localparam int SU_E  = 1;
    localparam int WP_E  = 10;  // ceil(75/8) for chip-select-to-end
    localparam int END_E = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rd_done, sram_cs_n, sram_we_n, sram_oe_n, dq_oe;
    logic [7:0]  rd_data, dq_out;
    logic [14:0] sram_addr;
    logic [7:0]  dq_in = 8'hEE;

    always #(CLK/2) clk = ~clk;

    asram_ctl #(.CLK_NS(CLK)) i_asram_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_done(rd_done), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int checks = 0, fails = 0;
    int issued = 0, cs_falls = 0;
    logic last_read = 1'b0;
    logic [7:0]  mem  [int];
    logic [7:0]  refm [int];
    logic [7:0]  rd_q [$];
    logic [22:0] wr_q [$];
    int          busy_q [$];

    function automatic logic [7:0] dflt(input logic [14:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: pushes the expected results, then hands the request over
    task automatic send(input logic wr, input logic [14:0] a, input logic [7:0] d);
        if (wr) begin
            busy_q.push_back((last_read ? FLT_E : 0) + SU_E + WP_E + END_E);
            wr_q.push_back({a, d});
            refm[int'(a)] = d;
            last_read = 1'b0;
        end else begin
            busy_q.push_back(ACC_E + 1);
            rd_q.push_back(refm.exists(int'(a)) ? refm[int'(a)] : dflt(a));
            last_read = 1'b1;
        end
        issued++;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // RAM model and monitor
    int rrun = 0, wrun = 0, busy = 0, gap = 255;
    logic prev_oe = 1'b0, prev_cs_n = 1'b1, prev_done = 1'b0, wbad = 1'b0, rd_end = 1'b0;
    logic [14:0] waddr;
    logic [7:0]  wdat;

    always @(negedge clk) begin
        if (rst_n) begin
            rd_end = 1'b0;
            if (prev_cs_n && !sram_cs_n) cs_falls++;
            prev_cs_n = sram_cs_n;
            // read strobes
            if (!sram_cs_n && !sram_oe_n) rrun++;
            else if (rrun != 0) begin
                chk(rrun == ACC_E, "R3 read strobe length", rrun, ACC_E);
                rrun = 0;
                rd_end = 1'b1;
            end
            if (!sram_cs_n && !sram_oe_n && sram_we_n && rrun >= ACC_E)
                dq_in = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : dflt(sram_addr);
            else
                dq_in = 8'hEE;
            // float gap and driver turn-on
            if (!sram_oe_n) gap = 0; else if (gap < 255) gap++;
            if (dq_oe && !prev_oe)
                chk(gap >= FLT_E, "R8 driver after float", gap, FLT_E);
            // write window
            if (!sram_cs_n && !sram_we_n) begin
                if (wrun == 0) chk(prev_oe, "R6 data driven before window", prev_oe, 1);
                wrun++;
                if (!sram_oe_n || !dq_oe) wbad = 1'b1;
                waddr = sram_addr; wdat = dq_out;
            end else if (wrun != 0) begin
                logic [22:0] e;
                chk(wrun == WP_E, "R5 write window length", wrun, WP_E);
                chk(!wbad, "R2 oe high and driver on in window", wbad, 0);
                chk(dq_oe, "R6 data held after window", dq_oe, 1);
                chk(sram_cs_n && sram_we_n, "R5 cs and we rise together", {sram_cs_n, sram_we_n}, 3);
                if (wr_q.size() != 0) begin
                    e = wr_q.pop_front();
                    chk(waddr == e[22:8], "R7 write address", waddr, e[22:8]);
                    chk(wdat == e[7:0], "R6 write data", wdat, e[7:0]);
                end else chk(1'b0, "R9 unexpected write", 0, 1);
                mem[int'(waddr)] = wdat;
                wrun = 0; wbad = 1'b0;
            end
            prev_oe = dq_oe;
            // read completion
            if (rd_done) begin
                logic [7:0] ev;
                chk(rd_end && !prev_done, "R4 done one cycle after access", {rd_end, prev_done}, 2);
                if (rd_q.size() != 0) begin
                    ev = rd_q.pop_front();
                    chk(rd_data == ev, "R4 read data", rd_data, ev);
                end else chk(1'b0, "R9 unexpected read", 0, 1);
            end
            prev_done = rd_done;
            // busy length
            if (!req_ready) busy++;
            else if (busy != 0) begin
                int eb;
                eb = (busy_q.size() != 0) ? busy_q.pop_front() : -1;
                chk(busy == eb, "R10 busy length", busy, eb);
                busy = 0;
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        chk(req_ready && sram_cs_n && sram_we_n && sram_oe_n && !dq_oe && !rd_done,
            "R1 reset levels", {req_ready, sram_cs_n, sram_we_n, sram_oe_n, dq_oe, rd_done}, 6'b111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && sram_cs_n && !dq_oe, "R1 idle after reset", {req_ready, sram_cs_n, dq_oe}, 3'b110);
        // R2 encodings and R7 addresses at the extremes
        send(1'b1, 15'h0000, 8'h00);
        send(1'b1, 15'h7FFF, 8'hFF);
        send(1'b1, 15'h1234, 8'h55);
        send(1'b0, 15'h0000, 8'h00);
        send(1'b0, 15'h7FFF, 8'h00);
        send(1'b0, 15'h4321, 8'h00);          // unwritten location
        send(1'b1, 15'h1234, 8'hAA);          // R8 write right after a read
        send(1'b0, 15'h1234, 8'h00);          // overwrite visible
        send(1'b0, 15'h1234, 8'h00);          // read after read
        for (int i = 0; i < 24; i++) begin   // R9 mixed traffic
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[0], {lfsr[4:1], 11'h0A5} ^ {12'h0, lfsr[7:5]}, lfsr[15:8]);
        end
        while (!req_ready || rd_q.size() != 0 || wr_q.size() != 0 || busy_q.size() != 0)
            @(negedge clk);
        repeat (2) @(negedge clk);
        chk(cs_falls == issued, "R9 each request taken once", cs_falls, issued);
        finish_run();
    end

endmodule